// File: doc/BRIEF.md
# LED Driver Serial Configuration Interface

This block is the serial loading front end of a sixteen-channel constant-current LED driver. A single serial data pin feeds one of two shift chains: a short chain of per-channel current trim values (6 bits each) or a long chain of per-channel brightness values (12 bits each). A select line picks the chain. A rising edge on the latch strobe copies the chosen chain into its holding register, and the holding registers drive the channel settings downstream.

The serial output always shows the top bit of the active chain, so several devices can be chained in series. The same output also returns status. After a latch, the first shift-clock rising edge with the select line low loads a status image into the brightness chain instead of shifting. The image holds per-channel open-LED flags and two thermal flags, and it is then clocked out. The open-LED flags are captured on the 33rd brightness-clock tick of a display period and held until they are loaded. All pins are sampled by one system clock, and edges on the serial clock and the latch are detected against that clock.

Top module: `led_serial_cfg`

## Requirements
- R1: After reset, both holding registers, both shift chains and `sdout` are zero, and no status load is pending.
- R2: On each serial-clock rising edge with `sel` high, the trim chain shifts in `sdin`, so the first of 96 bits ends up as channel 15 bit 5 and the last as channel 0 bit 0. A latch rising edge with `sel` high copies the chain so that `dc_hold[6*c+b]` is channel c bit b.
- R3: With `sel` low, the brightness chain (192 bits) shifts in the same way, with channel 15 bit 11 first. A latch with `sel` low makes `gs_hold[12*c+b]` equal to channel c bit b.
- R4: A latch updates only the holding register that `sel` chooses. The other holding register keeps its value.
- R5: `sdout` changes only on a serial-clock falling edge. It then takes the top bit of the chain that `sel` chooses (trim bit 95 or brightness bit 191).
- R6: The first serial-clock rising edge after a latch, if `sel` is low, loads the brightness chain instead of shifting, and the `sdin` bit on that edge is discarded. The loaded bits are: bits 191 down to 176 = held open-LED flags for channel 15 down to channel 0, bit 175 = `therm_err`, bit 174 = `therm_flag2`, and every lower bit = 0.
- R7: If `sel` is high on that first rising edge after a latch, the trim chain shifts normally and the pending status load is dropped. Later edges with `sel` low then shift normally.
- R8: The held open-LED flags are the value of `led_open` at the 33rd `gs_tick` pulse after `period_start`. Later changes to `led_open` do not alter them until the next period reaches its 33rd tick.
- R9: Shifting without a latch leaves both holding registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial shift clock level |
| sdin | input | 1 | Serial data in |
| latch | input | 1 | Latch strobe level; acts on its rising edge |
| sel | input | 1 | 1 = trim chain, 0 = brightness chain |
| gs_tick | input | 1 | One-cycle pulse per brightness-clock rising edge |
| period_start | input | 1 | One-cycle pulse at the start of a display period |
| led_open | input | 16 | Per-channel open-LED detection, channel 15 at the MSB |
| therm_err | input | 1 | Thermal error flag |
| therm_flag2 | input | 1 | Second thermal flag |
| sdout | output | 1 | Serial data out |
| dc_hold | output | 96 | Latched per-channel trim values |
| gs_hold | output | 192 | Latched per-channel brightness values |

## Verification
A shift chain that is wrong inside the block first shows up on `sdout`. A corrupt trim bit reaches the output 96 falling edges after it was shifted in, and a corrupt brightness bit 192 falling edges after. A wrong holding-register copy is visible on the cycle right after the latch edge. A status load that fires at the wrong time, or does not fire, changes the very next `sdout` bit, so the bench compares every falling edge against its own model of both chains. Flags captured on the wrong tick differ in the first 16 bits that follow the load.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;
  localparam int CH_DEF       = 16;
  localparam int DCB_DEF      = 6;
  localparam int GSB_DEF      = 12;
  localparam int LOD_EDGE_DEF = 33;

  // number of meaningful bits in the status image
  function automatic int status_width(input int ch);
    return ch + 2;
  endfunction

  // counter width needed to count up to a given tick
  function automatic int tick_cnt_width(input int edge_no);
    return $clog2(edge_no + 1);
  endfunction
endpackage

// File: rtl/strobe_edges.sv
module strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic latch,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic latch_rise
);
  logic sclk_q, latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      latch_q <= latch;
    end
  end

  assign sclk_rise  = sclk & ~sclk_q;
  assign sclk_fall  = ~sclk & sclk_q;
  assign latch_rise = latch & ~latch_q;
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         load_en,
  input  logic         din,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/lod_capture.sv
module lod_capture #(
  parameter int CH       = 16,
  parameter int LOD_EDGE = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_start,
  input  logic          gs_tick,
  input  logic [CH-1:0] led_open,
  output logic          lod_hit,
  output logic [CH-1:0] lod_held
);
  import led_cfg_pkg::*;
  localparam int CW = tick_cnt_width(LOD_EDGE);
  localparam logic [CW-1:0] LAST = CW'(LOD_EDGE);
  localparam logic [CW-1:0] HIT  = CW'(LOD_EDGE - 1);

  logic [CW-1:0] cnt;

  assign lod_hit = gs_tick && !period_start && (cnt == HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      lod_held <= '0;
    end else if (period_start) begin
      cnt <= '0;
    end else if (gs_tick && cnt < LAST) begin
      cnt <= cnt + 1'b1;
      if (lod_hit) lod_held <= led_open;
    end
  end
endmodule

// File: rtl/led_serial_cfg.sv
module led_serial_cfg #(
  parameter int CH       = led_cfg_pkg::CH_DEF,
  parameter int DC_BITS  = led_cfg_pkg::DCB_DEF,
  parameter int GS_BITS  = led_cfg_pkg::GSB_DEF,
  parameter int LOD_EDGE = led_cfg_pkg::LOD_EDGE_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sdin,
  input  logic                  latch,
  input  logic                  sel,
  input  logic                  gs_tick,
  input  logic                  period_start,
  input  logic [CH-1:0]         led_open,
  input  logic                  therm_err,
  input  logic                  therm_flag2,
  output logic                  sdout,
  output logic [CH*DC_BITS-1:0] dc_hold,
  output logic [CH*GS_BITS-1:0] gs_hold
);
  localparam int DCW = CH * DC_BITS;
  localparam int GSW = CH * GS_BITS;
  localparam int STW = led_cfg_pkg::status_width(CH);

  logic sclk_rise, sclk_fall, latch_rise;
  logic arm;
  logic status_load;
  logic dc_shift, gs_shift;
  logic lod_hit;
  logic [CH-1:0]  lod_held;
  logic [DCW-1:0] dc_sr;
  logic [GSW-1:0] gs_sr;
  logic [GSW-1:0] status_img;
  logic [DCW-1:0] dc_noload;

  strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .latch(latch),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .latch_rise(latch_rise)
  );

  lod_capture #(.CH(CH), .LOD_EDGE(LOD_EDGE)) u_lod (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .gs_tick(gs_tick),
    .led_open(led_open), .lod_hit(lod_hit), .lod_held(lod_held)
  );

  // named events for the checker
  assign status_load = sclk_rise && arm && !sel;
  assign dc_shift    = sclk_rise && sel;
  assign gs_shift    = sclk_rise && !sel && !arm;

  always_comb begin
    status_img = '0;
    status_img[GSW-1 -: STW] = {lod_held, therm_err, therm_flag2};
  end

  assign dc_noload = '0;

  shift_chain #(.W(DCW)) u_dc (
    .clk(clk), .rst_n(rst_n), .shift_en(dc_shift), .load_en(1'b0),
    .din(sdin), .load_val(dc_noload), .q(dc_sr)
  );

  shift_chain #(.W(GSW)) u_gs (
    .clk(clk), .rst_n(rst_n), .shift_en(gs_shift), .load_en(status_load),
    .din(sdin), .load_val(status_img), .q(gs_sr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          arm <= 1'b0;
    else if (latch_rise) arm <= 1'b1;
    else if (sclk_rise)  arm <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dc_hold <= '0;
      gs_hold <= '0;
    end else if (latch_rise) begin
      if (sel) dc_hold <= dc_sr;
      else     gs_hold <= gs_sr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sdout <= 1'b0;
    else if (sclk_fall) sdout <= sel ? dc_sr[DCW-1] : gs_sr[GSW-1];
  end
endmodule

// File: rtl/led_cfg_chk.sv
module led_cfg_chk #(
  parameter int CH  = 16,
  parameter int DCW = 96,
  parameter int GSW = 192
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sel,
  input logic           sclk_rise,
  input logic           sclk_fall,
  input logic           latch_rise,
  input logic           status_load,
  input logic           lod_hit,
  input logic [CH-1:0]  led_open,
  input logic [CH-1:0]  lod_held,
  input logic [DCW-1:0] dc_sr,
  input logic [GSW-1:0] gs_sr,
  input logic [DCW-1:0] dc_hold,
  input logic [GSW-1:0] gs_hold,
  input logic           sdout
);
  // R2
  dc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && sel) |=> dc_hold == $past(dc_sr));
  // R3
  gs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && !sel) |=> gs_hold == $past(gs_sr));
  // R4
  dc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_rise && sel) |=> $stable(dc_hold));
  // R4
  gs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_rise && !sel) |=> $stable(gs_hold));
  // R5
  sdout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sdout));
  // R6
  status_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_load |=> gs_sr[GSW-1 -: CH] == $past(lod_held));
  // R7
  gs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && sel) |=> $stable(gs_sr));
  // R8
  lod_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lod_hit |=> lod_held == $past(led_open));
endmodule

bind led_serial_cfg led_cfg_chk #(.CH(CH), .DCW(DCW), .GSW(GSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .latch_rise(latch_rise), .status_load(status_load),
  .lod_hit(lod_hit), .led_open(led_open), .lod_held(lod_held),
  .dc_sr(dc_sr), .gs_sr(gs_sr), .dc_hold(dc_hold), .gs_hold(gs_hold),
  .sdout(sdout)
);

// File: tb/sim_led_serial_cfg.sv
module sim_led_serial_cfg;
  localparam int CH  = 16;
  localparam int DCW = 96;
  localparam int GSW = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, latch = 1'b0, sel = 1'b0;
  logic gs_tick = 1'b0, period_start = 1'b0;
  logic [CH-1:0] led_open = '0;
  logic therm_err = 1'b0, therm_flag2 = 1'b0;
  logic sdout;
  logic [DCW-1:0] dc_hold;
  logic [GSW-1:0] gs_hold;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  logic [DCW-1:0] m_dc = '0, m_dc_hold = '0, dc_a, dc_b;
  logic [GSW-1:0] m_gs = '0, m_gs_hold = '0, gs_a;
  logic [CH-1:0]  m_lod = '0;
  bit m_arm = 1'b0;

  // scoreboard queues
  bit    exp_q[$];
  bit    care_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  led_serial_cfg u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .latch(latch),
    .sel(sel), .gs_tick(gs_tick), .period_start(period_start),
    .led_open(led_open), .therm_err(therm_err), .therm_flag2(therm_flag2),
    .sdout(sdout), .dc_hold(dc_hold), .gs_hold(gs_hold)
  );

  function automatic logic [CH-1:0] lod_pat(input int i);
    return 16'hA5C3 ^ 16'(i * 16'h0101);
  endfunction

  task automatic chk_vec(input string tag, input logic [GSW-1:0] act,
                         input logic [GSW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one serial bit: rise then fall, model updated per requirements
  task automatic pulse(input logic d, input bit care, input string tag);
    @(negedge clk);
    sdin = d;
    sclk = 1'b1;
    if (sel) begin
      m_arm = 1'b0;
      m_dc  = {m_dc[DCW-2:0], d};
    end else if (m_arm) begin
      m_arm = 1'b0;
      m_gs  = '0;
      m_gs[GSW-1 -: CH+2] = {m_lod, therm_err, therm_flag2};
    end else begin
      m_gs = {m_gs[GSW-2:0], d};
    end
    repeat (2) @(negedge clk);
    exp_q.push_back(sel ? m_dc[DCW-1] : m_gs[GSW-1]);
    care_q.push_back(care);
    tag_q.push_back(tag);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_latch();
    @(negedge clk);
    latch = 1'b1;
    if (sel) m_dc_hold = m_dc;
    else     m_gs_hold = m_gs;
    m_arm = 1'b1;
    repeat (2) @(negedge clk);
    latch = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare sdout after each falling edge of the serial clock
  always @(negedge sclk) begin
    repeat (2) @(negedge clk);
    if (exp_q.size() > 0) begin
      bit e, c;
      string t;
      e = exp_q.pop_front();
      c = care_q.pop_front();
      t = tag_q.pop_front();
      if (c) begin
        tests++;
        if (sdout !== e) begin
          fails++;
          $display("FAIL %s: sdout act=%0b exp=%0b", t, sdout, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CH; c++) begin
      dc_a[c*6 +: 6]  = 6'((c * 7 + 3) % 64);
      dc_b[c*6 +: 6]  = 6'((c * 13 + 40) % 64);
      gs_a[c*12 +: 12] = 12'((c * 257 + 91) % 4096);
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk_vec("R1 dc_hold", GSW'(dc_hold), '0);
    chk_vec("R1 gs_hold", gs_hold, '0);
    chk_vec("R1 sdout", GSW'(sdout), '0);

    // R8 open-LED capture on the 33rd tick
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      led_open = lod_pat(i);
      gs_tick  = 1'b1;
      @(negedge clk);
      gs_tick  = 1'b0;
    end
    m_lod = lod_pat(33);
    led_open = 16'h0F0F;

    // R2 / R5 trim chain load, MSB first
    sel = 1'b1;
    for (int i = DCW - 1; i >= 0; i--) pulse(dc_a[i], 1'b1, "R5 dc stream");
    do_latch();
    chk_vec("R2 dc_hold", GSW'(dc_hold), GSW'(dc_a));
    chk_vec("R4 gs_hold kept", gs_hold, '0);

    // R7 first edge after latch with sel high drops the status load
    pulse(1'b1, 1'b1, "R7 dc shift");
    sel = 1'b0;
    for (int i = GSW - 1; i >= 0; i--) pulse(gs_a[i], 1'b1, "R3 gs stream");
    do_latch();
    chk_vec("R3 gs_hold", gs_hold, gs_a);
    chk_vec("R7 gs_hold no status", gs_hold, m_gs_hold);
    chk_vec("R4 dc_hold kept", GSW'(dc_hold), GSW'(dc_a));

    // R6 / R8 status readback
    therm_err = 1'b1;
    therm_flag2 = 1'b0;
    for (int i = 0; i < GSW; i++) pulse(1'b1, 1'b1, i < CH ? "R8 flags" : "R6 status");
    chk_vec("R9 gs_hold after shift", gs_hold, gs_a);

    // second status read with other thermal values
    do_latch();
    therm_err = 1'b0;
    therm_flag2 = 1'b1;
    for (int i = 0; i < CH + 4; i++) pulse(1'b0, 1'b1, "R6 status2");

    // R9 shifting without latch
    sel = 1'b1;
    for (int i = 0; i < 10; i++) pulse(1'b1, 1'b1, "R9 shift");
    chk_vec("R9 dc_hold", GSW'(dc_hold), GSW'(dc_a));
    chk_vec("R9 gs_hold", gs_hold, m_gs_hold);

    // R2 second pattern
    for (int i = DCW - 1; i >= 0; i--) pulse(dc_b[i], 1'b1, "R2 dc stream b");
    do_latch();
    chk_vec("R2 dc_hold b", GSW'(dc_hold), GSW'(dc_b));
    chk_vec("R4 gs_hold kept b", gs_hold, m_gs_hold);

    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule